// File: doc/BRIEF.md
# Processor interrupt entry and return sequencer

This block is the control slice of a small processor that takes an external interrupt and later returns from it. The instruction datapath reports each finished instruction with a one-cycle strobe, a two-bit operation class and the already-incremented program counter. Between that instruction and the next fetch, the sequencer samples a single request line, provided interrupts are enabled. When it takes the request, it saves the return address in a dedicated register and disables further interrupts. It then raises an acknowledge line for one cycle and latches the vector number that the device drives onto a small bus. It fetches the handler address from a vector table in memory and writes the current mode onto a downward-growing system stack. Finally it hands control to the handler in kernel mode, running on the system stack.

The block also performs three control operations: enable interrupts, disable interrupts, and return from interrupt. The return is a short, uninterruptible sequence. It pops the saved mode and switches back to the user stack if that mode is user. It then reloads the program counter from the return register and re-enables interrupts. Memory is a single synchronous port: read data appears in the cycle after the address. While `busy` is high, the datapath must hold off its fetch.

Top module: `irq_entry_seq`

## Requirements
- R1: After a synchronous reset the state is as follows. `pc` equals RESET_PC, `ret_addr` is 0, `kernel_mode` is 0 (user), and `int_en`, `inta` and `busy` are 0. `sp_active` equals USP_INIT, and the system stack pointer equals SSP_INIT.
- R2: The request line is sampled only in a cycle where `insn_done` is high and `busy` is low. The flag value used is the one in effect after that instruction's own operation: enable-interrupt counts as enabled and disable-interrupt as disabled. At any other time `irq_req` has no effect.
- R3: On taking an interrupt, the same clock edge does three things. `ret_addr` loads `pc_next`, `int_en` clears, and `sp_active` switches to the system stack pointer.
- R4: `inta` is high for exactly one cycle: the cycle after the request is taken. `vec_bus` is latched at the end of that cycle, and `int_en` is low throughout it.
- R5: The cycle after the acknowledge, `mem_addr` is VEC_BASE plus the vector and `mem_we` is low. On the next edge, `pc` loads the word returned.
- R6: In the third entry cycle, the system stack pointer is decremented and the old mode is written to the new address. The mode is written as a word whose bit 0 is 1 for kernel and 0 for user. On that edge the mode becomes kernel and `busy` falls, so `busy` is high for exactly three cycles.
- R7: The return operation has `insn_op` = 3. It reads the word at the system stack pointer and then increments that pointer. It restores the mode from bit 0 of the word, and selects the user stack if that bit is 0. It loads `pc` from `ret_addr` and sets `int_en`. `busy` is high for its two cycles, and the request line is not sampled inside them.
- R8: `insn_op` 1 sets `int_en` and `insn_op` 2 clears it. Both, like `insn_op` 0 (plain), load `pc` from `pc_next`.
- R9: An `insn_done` strobe that arrives while `busy` is high is ignored.
- R10: The standard case starts from the reset stack pointers with vector 40 and table word 40 holding 1000. Entering from `pc_next` = 20000 yields `pc` = 1000, `ret_addr` = 20000 and system stack pointer 299. Memory word 299 holds 0 (user).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_done | input | 1 | Current instruction finished this cycle |
| insn_op | input | 2 | 0 plain, 1 enable interrupts, 2 disable interrupts, 3 return from interrupt |
| pc_next | input | W | Incremented program counter of the finished instruction |
| irq_req | input | 1 | Interrupt request line |
| inta | output | 1 | Interrupt acknowledge |
| vec_bus | input | VEC_W | Vector number driven by the device during acknowledge |
| mem_addr | output | W | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | W | Memory write data |
| mem_rdata | input | W | Memory read data, one cycle after address |
| pc | output | W | Program counter |
| ret_addr | output | W | Return address register |
| sp_active | output | W | Currently selected stack pointer |
| kernel_mode | output | 1 | 1 when in kernel mode |
| int_en | output | 1 | Interrupt enable flag |
| busy | output | 1 | Entry or return sequence in progress |

## Verification
Several properties are checked on every cycle:
- The acknowledge is a lone pulse seen only with interrupts disabled.
- `ret_addr` holds the interrupted `pc_next` once the acknowledge starts.
- Every stack write is followed by kernel mode on the system stack, at the address just written.
- The enable flag rises only through the enable operation or the end of a return.
- A return that lands in user mode leaves interrupts enabled on the user stack.

Only the bench's scenarios can show the rest, comparing against a behavioural model each clock. Those behaviours are: the vector fetched from the right table entry, nested entry pushing kernel mode, and strobes ignored mid-sequence. They also cover the value popped deciding whether the stack is swapped back.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [1:0] {
        OP_PLAIN = 2'd0,
        OP_IEN   = 2'd1,
        OP_IDIS  = 2'd2,
        OP_IRET  = 2'd3
    } insn_op_e;

    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_ACK   = 3'd1,
        ST_TBL   = 3'd2,
        ST_PUSH  = 3'd3,
        ST_POPRD = 3'd4,
        ST_POPWB = 3'd5
    } seq_state_e;

    typedef enum logic {
        MODE_USER   = 1'b0,
        MODE_KERNEL = 1'b1
    } cpu_mode_e;

    // one strobe per micro-step of the sequencer
    typedef struct packed {
        logic retire;  // accepted instruction: pc <= pc_next
        logic enter;   // interrupt taken this cycle
        logic set_ie;
        logic clr_ie;
        logic ack;
        logic tbl_rd;
        logic push;
        logic pop_rd;
        logic pop_wb;
    } seq_ctrl_t;

    // enable flag as it stands once the finishing instruction's op applies
    function automatic logic ie_after_op(input insn_op_e op, input logic ie_now);
        case (op)
            OP_IEN:  return 1'b1;
            OP_IDIS: return 1'b0;
            default: return ie_now;
        endcase
    endfunction

endpackage

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
    import irq_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      insn_done,
    input  insn_op_e  insn_op,
    input  logic      irq_req,
    input  logic      int_en,
    output seq_ctrl_t ctrl,
    output logic      busy
);

    seq_state_e st, nxt;

    always_ff @(posedge clk) begin
        if (rst) st <= ST_RUN;
        else     st <= nxt;
    end

    always_comb begin
        ctrl = '0;
        nxt  = st;
        unique case (st)
            ST_RUN: begin
                if (insn_done) begin
                    if (insn_op == OP_IRET) begin
                        nxt = ST_POPRD;
                    end else begin
                        ctrl.retire = 1'b1;
                        ctrl.set_ie = (insn_op == OP_IEN);
                        ctrl.clr_ie = (insn_op == OP_IDIS);
                        if (irq_req && ie_after_op(insn_op, int_en)) begin
                            ctrl.enter = 1'b1;
                            nxt        = ST_ACK;
                        end
                    end
                end
            end
            ST_ACK: begin
                ctrl.ack = 1'b1;
                nxt      = ST_TBL;
            end
            ST_TBL: begin
                ctrl.tbl_rd = 1'b1;
                nxt         = ST_PUSH;
            end
            ST_PUSH: begin
                ctrl.push = 1'b1;
                nxt       = ST_RUN;
            end
            ST_POPRD: begin
                ctrl.pop_rd = 1'b1;
                nxt         = ST_POPWB;
            end
            ST_POPWB: begin
                ctrl.pop_wb = 1'b1;
                nxt         = ST_RUN;
            end
            default: nxt = ST_RUN;
        endcase
    end

    assign busy = (st != ST_RUN);

    // R9
    busy_no_retire_chk: assert property (@(posedge clk) disable iff (rst)
        (insn_done && busy) |=> !$rose(int_en) || $past(ctrl.pop_wb));

endmodule

// File: rtl/irq_arch_regs.sv
module irq_arch_regs
    import irq_seq_pkg::*;
#(
    parameter int unsigned   W        = 16,
    parameter int unsigned   VEC_W    = 8,
    parameter logic [W-1:0]  RESET_PC = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  seq_ctrl_t        ctrl,
    input  logic [W-1:0]     pc_next,
    input  logic [VEC_W-1:0] vec_bus,
    input  logic [W-1:0]     mem_rdata,
    output logic [W-1:0]     pc,
    output logic [W-1:0]     ret_addr,
    output logic             int_en,
    output cpu_mode_e        mode,
    output logic [VEC_W-1:0] vec
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc       <= RESET_PC;
            ret_addr <= '0;
            int_en   <= 1'b0;
            mode     <= MODE_USER;
            vec      <= '0;
        end else begin
            if (ctrl.retire) pc <= pc_next;
            if (ctrl.enter)  ret_addr <= pc_next;
            if (ctrl.set_ie) int_en <= 1'b1;
            if (ctrl.clr_ie || ctrl.enter) int_en <= 1'b0;
            if (ctrl.ack)    vec <= vec_bus;
            if (ctrl.push) begin
                pc   <= mem_rdata;
                mode <= MODE_KERNEL;
            end
            if (ctrl.pop_wb) begin
                pc     <= ret_addr;
                mode   <= cpu_mode_e'(mem_rdata[0]);
                int_en <= 1'b1;
            end
        end
    end

    // R8
    ie_rise_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(int_en) |-> ($past(ctrl.set_ie) || $past(ctrl.pop_wb)));

endmodule

// File: rtl/irq_stack_unit.sv
module irq_stack_unit
    import irq_seq_pkg::*;
#(
    parameter int unsigned  W        = 16,
    parameter logic [W-1:0] USP_INIT = W'(512),
    parameter logic [W-1:0] SSP_INIT = W'(300)
) (
    input  logic         clk,
    input  logic         rst,
    input  seq_ctrl_t    ctrl,
    input  logic         popped_kernel,
    output logic [W-1:0] sp_user,
    output logic [W-1:0] sp_sys,
    output logic [W-1:0] sp_active,
    output logic [W-1:0] push_addr
);

    logic sys_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_user <= USP_INIT;
            sp_sys  <= SSP_INIT;
            sys_sel <= 1'b0;
        end else begin
            if (ctrl.enter) sys_sel <= 1'b1;
            if (ctrl.push)  sp_sys  <= push_addr;
            if (ctrl.pop_wb) begin
                sp_sys <= sp_sys + W'(1);
                if (!popped_kernel) sys_sel <= 1'b0;
            end
        end
    end

    assign push_addr = sp_sys - W'(1);
    assign sp_active = sys_sel ? sp_sys : sp_user;

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int unsigned  W         = 16,
    parameter int unsigned  VEC_W     = 8,
    parameter logic [W-1:0] RESET_PC  = '0,
    parameter logic [W-1:0] VEC_BASE  = '0,
    parameter logic [W-1:0] USP_INIT  = W'(512),
    parameter logic [W-1:0] SSP_INIT  = W'(300)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             insn_done,
    input  logic [1:0]       insn_op,
    input  logic [W-1:0]     pc_next,
    input  logic             irq_req,
    output logic             inta,
    input  logic [VEC_W-1:0] vec_bus,
    output logic [W-1:0]     mem_addr,
    output logic             mem_we,
    output logic [W-1:0]     mem_wdata,
    input  logic [W-1:0]     mem_rdata,
    output logic [W-1:0]     pc,
    output logic [W-1:0]     ret_addr,
    output logic [W-1:0]     sp_active,
    output logic             kernel_mode,
    output logic             int_en,
    output logic             busy
);

    localparam int unsigned PADW = W - VEC_W;

    seq_ctrl_t        ctrl;
    cpu_mode_e        mode;
    logic [VEC_W-1:0] vec;
    logic [W-1:0]     sp_user, sp_sys, push_addr, tbl_addr;

    irq_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .insn_done (insn_done),
        .insn_op   (insn_op_e'(insn_op)),
        .irq_req   (irq_req),
        .int_en    (int_en),
        .ctrl      (ctrl),
        .busy      (busy)
    );

    irq_arch_regs #(.W(W), .VEC_W(VEC_W), .RESET_PC(RESET_PC)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .pc_next   (pc_next),
        .vec_bus   (vec_bus),
        .mem_rdata (mem_rdata),
        .pc        (pc),
        .ret_addr  (ret_addr),
        .int_en    (int_en),
        .mode      (mode),
        .vec       (vec)
    );

    irq_stack_unit #(.W(W), .USP_INIT(USP_INIT), .SSP_INIT(SSP_INIT)) u_stk (
        .clk           (clk),
        .rst           (rst),
        .ctrl          (ctrl),
        .popped_kernel (mem_rdata[0]),
        .sp_user       (sp_user),
        .sp_sys        (sp_sys),
        .sp_active     (sp_active),
        .push_addr     (push_addr)
    );

    assign tbl_addr = VEC_BASE + {{PADW{1'b0}}, vec};

    // single memory port shared by the table read, the push and the pop
    always_comb begin
        mem_addr = '0;
        if (ctrl.tbl_rd)      mem_addr = tbl_addr;
        else if (ctrl.push)   mem_addr = push_addr;
        else if (ctrl.pop_rd) mem_addr = sp_sys;
    end

    assign mem_we      = ctrl.push;
    assign mem_wdata   = {{(W-1){1'b0}}, logic'(mode)};
    assign inta        = ctrl.ack;
    assign kernel_mode = (mode == MODE_KERNEL);

    // R4
    ack_masked_chk: assert property (@(posedge clk) disable iff (rst)
        inta |-> (!int_en && busy));

    // R4
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        inta |=> !inta);

    // R3
    ret_saved_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(inta) |-> (ret_addr == $past(pc_next)) && (sp_active == sp_sys));

    // R6
    push_lands_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> kernel_mode && (sp_active == $past(mem_addr)) && !busy);

    // R7
    user_return_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !kernel_mode) |-> (int_en && sp_active == sp_user));

endmodule

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;

    localparam int W = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        insn_done = 1'b0;
    logic [1:0]  insn_op = 2'd0;
    logic [15:0] pc_next = '0;
    logic        irq_req = 1'b0;
    logic        inta;
    logic [7:0]  vec_bus;
    logic [7:0]  dev_vec = 8'd40;
    logic [15:0] mem_addr, mem_wdata, mem_rdata, pc, ret_addr, sp_active;
    logic        mem_we, kernel_mode, int_en, busy;

    int nchk = 0, nfail = 0, cyc = 0;

    always #5 clk = ~clk;

    irq_entry_seq u0 (
        .clk(clk), .rst(rst), .insn_done(insn_done), .insn_op(insn_op),
        .pc_next(pc_next), .irq_req(irq_req), .inta(inta), .vec_bus(vec_bus),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .pc(pc), .ret_addr(ret_addr),
        .sp_active(sp_active), .kernel_mode(kernel_mode), .int_en(int_en),
        .busy(busy)
    );

    // device: drives its vector only while acknowledged
    assign vec_bus = inta ? dev_vec : 8'hEE;

    // synchronous memory seen by the design
    logic [15:0] mem [0:1023];
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[9:0]];
    end

    // behavioural reference model
    logic [15:0] mm [0:1023];
    logic [15:0] m_pc, m_ret, m_usp, m_ssp, m_tmp;
    logic        m_ie, m_kern, m_sys;
    logic [7:0]  m_vec;
    int          m_ph;

    always @(posedge clk) begin
        if (rst) begin
            m_pc = 0; m_ret = 0; m_usp = 512; m_ssp = 300;
            m_ie = 0; m_kern = 0; m_sys = 0; m_vec = 0; m_ph = 0;
        end else begin
            case (m_ph)
                0: if (insn_done) begin
                    if (insn_op == 2'd3) m_ph = 4;
                    else begin
                        m_pc = pc_next;
                        if (insn_op == 2'd1) m_ie = 1;
                        if (insn_op == 2'd2) m_ie = 0;
                        if (irq_req && m_ie) begin
                            m_ret = pc_next; m_ie = 0; m_sys = 1; m_ph = 1;
                        end
                    end
                end
                1: begin m_vec = dev_vec; m_ph = 2; end
                2: begin m_tmp = mm[m_vec]; m_ph = 3; end
                3: begin
                    m_pc = m_tmp; m_ssp = m_ssp - 1;
                    mm[m_ssp[9:0]] = {15'd0, m_kern};
                    m_kern = 1; m_ph = 0;
                end
                4: m_ph = 5;
                default: begin
                    m_kern = mm[m_ssp[9:0]][0];
                    if (!m_kern) m_sys = 0;
                    m_ssp = m_ssp + 1; m_pc = m_ret; m_ie = 1; m_ph = 0;
                end
            endcase
        end
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // cycle compare against the model
    always @(negedge clk) begin
        cyc++;
        if (cyc > 5000) begin
            nfail++;
            $display("FAIL watchdog R9 actual=%0d expected=%0d", cyc, 5000);
            $display("[TB] %0d tests run, %0d failed", nchk, nfail);
            $finish;
        end
        check(pc == m_pc, "R5 pc", pc, m_pc);
        check(ret_addr == m_ret, "R3 ret_addr", ret_addr, m_ret);
        check(int_en == m_ie, "R8 int_en", int_en, m_ie);
        check(kernel_mode == m_kern, "R6 mode", kernel_mode, m_kern);
        check(sp_active == (m_sys ? m_ssp : m_usp), "R7 sp_active", sp_active,
              m_sys ? m_ssp : m_usp);
        check(inta == (m_ph == 1), "R4 inta", inta, m_ph == 1);
        check(busy == (m_ph != 0), "R2 busy", busy, m_ph != 0);
    end

    task automatic put_word(input int a, input logic [15:0] d);
        mem[a] = d; mm[a] = d;
    endtask

    task automatic do_insn(input logic [1:0] op, input logic [15:0] p);
        @(negedge clk);
        insn_done = 1'b1; insn_op = op; pc_next = p;
        @(negedge clk);
        insn_done = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) put_word(i, 16'd0);
        put_word(40, 16'd1000);
        put_word(41, 16'd2000);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(pc == 0 && ret_addr == 0, "R1 pc/ret", pc, 0);
        check(!kernel_mode && !int_en && !inta && !busy, "R1 flags",
              {kernel_mode, int_en, inta, busy}, 0);
        check(sp_active == 512, "R1 sp", sp_active, 512);

        // R2: request ignored while disabled
        irq_req = 1'b1;
        do_insn(2'd0, 16'd1);
        do_insn(2'd2, 16'd2);
        @(negedge clk);
        check(!busy && pc == 2, "R2 masked", pc, 2);

        // R10 via enable then immediate entry; R9 strobe during entry
        dev_vec = 8'd40;
        do_insn(2'd1, 16'd20000);
        do_insn(2'd0, 16'h5555);
        irq_req = 1'b0;
        wait_idle();
        check(pc == 1000, "R10 pc", pc, 1000);
        check(ret_addr == 20000, "R10 ret", ret_addr, 20000);
        check(sp_active == 299, "R10 sp", sp_active, 299);
        check(mem[299] == 0, "R10 pushed mode", mem[299], 0);
        check(kernel_mode && !int_en, "R6 kernel", kernel_mode, 1);

        // nested entry from kernel, R8 enable
        do_insn(2'd0, 16'd1001);
        do_insn(2'd1, 16'd1002);
        check(!busy && int_en, "R8 enable", int_en, 1);
        dev_vec = 8'd41; irq_req = 1'b1;
        do_insn(2'd0, 16'd1003);
        irq_req = 1'b0;
        wait_idle();
        check(pc == 2000 && sp_active == 298, "R5 nested pc", pc, 2000);
        check(mem[298] == 1, "R6 pushed kernel", mem[298], 1);

        // R7 return staying in kernel
        do_insn(2'd3, 16'd0);
        wait_idle();
        check(pc == 1003 && kernel_mode && int_en, "R7 kret pc", pc, 1003);
        check(sp_active == 299, "R7 kret sp", sp_active, 299);

        // disabled, then return to user
        do_insn(2'd2, 16'd1004);
        irq_req = 1'b1;
        do_insn(2'd0, 16'd1005);
        @(negedge clk);
        check(!busy && pc == 1005, "R2 after disable", pc, 1005);
        irq_req = 1'b0;
        do_insn(2'd3, 16'd0);
        wait_idle();
        check(!kernel_mode && int_en, "R7 user mode", kernel_mode, 0);
        check(sp_active == 512 && pc == 1003, "R7 user sp", sp_active, 512);

        // taken again from user after return
        dev_vec = 8'd40; irq_req = 1'b1;
        do_insn(2'd0, 16'd3000);
        irq_req = 1'b0;
        wait_idle();
        check(pc == 1000 && ret_addr == 3000 && sp_active == 299, "R3 reentry",
              ret_addr, 3000);
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

endmodule